// File: doc/BRIEF.md
# Clocked Synchronous Serial Interface

This block moves bytes over a three-wire synchronous link: a data output, a data input and one serial clock that both directions share. The serial clock is generated inside the block from a programmable divider or taken from an external pin. Software works the block through a small register port. It uses that port to select the clock source, set the divider, turn the transmitter and the receiver on and off, mask three interrupt outputs, write bytes to send, read bytes received and inspect the status flags.

When the transmitter is turned off, the transmit path returns to idle at once and any pending byte is dropped. When the receiver is turned off, its flags and its last received byte are left as they were, so software can still inspect them. With the internal clock and the receiver on, the clock runs without a break, so bytes keep arriving back to back. The clock stops only when a byte is lost because the previous one was not read, or when the receiver is turned off.

Top module: `sync_serial_if`

## Requirements
- R1: After reset, status reads 0x03 (bit0 transmit-empty=1, bit1 transmit-end=1, bit2 receive-full=0, bit3 overrun=0, bit4 parity error=0, bit5 framing error=0). txd_o and sck_o are 1, both output enables are 0, and all interrupt outputs are 0.
- R2: Register addresses are 0 control, 1 divider, 2 transmit data, 3 receive data and 4 status. Control bits are: bit0 transmit on, bit1 receive on, bit2 external clock, bit3 receive-full irq mask, bit4 transmit-empty irq mask, bit5 transmit-end irq mask. Writes to control bit2 and to the divider are ignored while transmit or receive is on, and both read back unchanged.
- R3: With the internal clock selected, sck_oe_o is 1 while either direction is on. The clock idles at 1 and, while running, has a period of 2*(N+1) system clocks, N being the divider value.
- R4: A byte is sent least significant bit first. txd_o changes on falling serial clock edges and holds each bit across the following rising edge. Writing transmit data clears transmit-empty. Transmit-empty sets again when the byte moves to the shifter. Transmit-end sets when a frame ends with no byte pending.
- R5: Eight bits of rxd_i are sampled on rising serial clock edges, least significant bit first. They then appear at the receive data address with receive-full set. A read of that address clears receive-full.
- R6: If a byte completes while receive-full is still 1, overrun is set, the byte is discarded and receive data keeps the old value. With the internal clock, the serial clock then stops at 1. Writing 1 to status bits 3..5 clears those flags.
- R7: With the internal clock and the receiver on, the serial clock keeps running after a byte completes, until an overrun occurs or the receiver is turned off.
- R8: Turning the transmitter off sets transmit-empty and transmit-end, clears the shifter and drops a pending byte. After it is turned back on, txd_o stays 1.
- R9: Turning the receiver off leaves receive-full, overrun, the error flags and receive data unchanged.
- R10: With the external clock selected, sck_oe_o is 0 and the divider value has no effect. Bits move on the edges of sck_i.
- R11: txd_oe_o equals the transmit-on bit, and txd_o is 1 while the transmitter is off. While the receiver is off, clock edges on sck_i and rxd_i have no effect on receive data or on receive-full.
- R12: Each interrupt output is the AND of its mask bit and its flag: receive-full, transmit-empty and transmit-end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects only) |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Internal serial clock |
| sck_oe_o | output | 1 | Drive enable for the serial clock pin |
| txd_o | output | 1 | Serial data out |
| txd_oe_o | output | 1 | Drive enable for the data out pin |
| rxd_i | input | 1 | Serial data in |
| irq_rxf_o | output | 1 | Receive-full interrupt |
| irq_txe_o | output | 1 | Transmit-empty interrupt |
| irq_tend_o | output | 1 | Transmit-end interrupt |

## Verification
A register write takes effect on the clock edge that ends its strobe cycle, and a read returns data combinationally in the same cycle. An sck_i edge reaches the shifters SYNC_STAGES+1 system cycles later. The bench therefore holds every external clock phase for eight system cycles: txd_o is captured at the end of the low phase, and rxd_i stays stable through the whole high phase. With the internal clock, the line toggles every N+1 cycles. The bench measures the period from falling edge to falling edge at the inactive clock edge. Status checks run a fixed number of cycles after enable, with margin on both sides of the instant each byte completes.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef logic [2:0] reg_addr_t;
  localparam reg_addr_t A_CTRL = 3'd0;
  localparam reg_addr_t A_BRR  = 3'd1;
  localparam reg_addr_t A_TXD  = 3'd2;
  localparam reg_addr_t A_RXD  = 3'd3;
  localparam reg_addr_t A_STAT = 3'd4;

  localparam int CTRL_W = 6;
  localparam int STAT_W = 6;

  typedef struct packed {
    logic ie_tend;
    logic ie_txe;
    logic ie_rxf;
    logic ext_clk;
    logic rx_en;
    logic tx_en;
  } ctrl_t;
endpackage

// File: rtl/ssi_clk_gen.sv
module ssi_clk_gen #(
  parameter int BRR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_i,
  input  logic             run_i,
  input  logic [BRR_W-1:0] brr_i,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int SR_W = SYNC_STAGES + 1;

  logic [BRR_W-1:0] cnt_q;
  logic             lvl_q;
  logic [SR_W-1:0]  sync_q;
  logic             wrap;
  logic             rise_int, fall_int, rise_ext, fall_ext;

  assign wrap = run_i && (cnt_q == brr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (wrap) begin
      cnt_q <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SR_W-2:0], sck_i};
  end

  // internal edges are flagged in the cycle whose clock edge moves the line
  assign fall_int = wrap && lvl_q;
  assign rise_int = wrap && !lvl_q;
  assign fall_ext = sync_q[SR_W-1] && !sync_q[SR_W-2];
  assign rise_ext = !sync_q[SR_W-1] && sync_q[SR_W-2];

  assign rise_o = ext_i ? rise_ext : rise_int;
  assign fall_o = ext_i ? fall_ext : fall_int;
  assign sck_o  = lvl_q;
endmodule

// File: rtl/ssi_tx.sv
module ssi_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              kill_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic [DATA_W-1:0] tdr_o,
  output logic              txd_o,
  output logic              busy_o,
  output logic              txe_o,
  output logic              tend_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic [DATA_W-1:0] tdr_q, sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, txe_q, tend_q, txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdr_q  <= '0;
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      txe_q  <= 1'b1;
      tend_q <= 1'b1;
      txd_q  <= 1'b1;
    end else if (kill_i) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      txe_q  <= 1'b1;
      tend_q <= 1'b1;
      txd_q  <= 1'b1;
    end else begin
      if (en_i && !busy_q && !txe_q) begin
        sr_q   <= tdr_q;
        cnt_q  <= '0;
        busy_q <= 1'b1;
        txe_q  <= 1'b1;
      end else if (busy_q && fall_i && cnt_q != LAST) begin
        txd_q <= sr_q[0];
        sr_q  <= sr_q >> 1;
        cnt_q <= cnt_q + 1'b1;
      end else if (busy_q && rise_i && cnt_q == LAST) begin
        if (!txe_q) begin
          sr_q  <= tdr_q;
          cnt_q <= '0;
          txe_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
          tend_q <= 1'b1;
          txd_q  <= 1'b1;
        end
      end
      if (wr_i) begin
        tdr_q  <= wdata_i;
        txe_q  <= 1'b0;
        tend_q <= 1'b0;
      end
    end
  end

  assign tdr_o  = tdr_q;
  assign txd_o  = txd_q;
  assign busy_o = busy_q;
  assign txe_o  = txe_q;
  assign tend_o = tend_q;
endmodule

// File: rtl/ssi_rx.sv
module ssi_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rise_i,
  input  logic              rxd_i,
  input  logic              rd_clr_i,
  input  logic [2:0]        w1c_i,
  output logic [DATA_W-1:0] rdr_o,
  output logic              rxf_o,
  output logic              ovr_o,
  output logic              per_o,
  output logic              fer_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q, rdr_q, next_sr;
  logic [CNT_W-1:0]  cnt_q;
  logic              rxf_q, ovr_q, per_q, fer_q;
  logic              take, done;

  assign next_sr = {rxd_i, sr_q[DATA_W-1:1]};
  assign take    = en_i && rise_i && !ovr_q;
  assign done    = take && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      rdr_q <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (take) begin
      sr_q <= next_sr;
      if (done) begin
        cnt_q <= '0;
        if (!rxf_q) rdr_q <= next_sr;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxf_q <= 1'b0;
      ovr_q <= 1'b0;
      per_q <= 1'b0;
      fer_q <= 1'b0;
    end else begin
      rxf_q <= (done && !rxf_q) || (rxf_q && !rd_clr_i);
      ovr_q <= (done && rxf_q) || (ovr_q && !w1c_i[0]);
      // no parity or stop bit in clocked framing: these only hold and clear
      per_q <= per_q && !w1c_i[1];
      fer_q <= fer_q && !w1c_i[2];
    end
  end

  assign rdr_o = rdr_q;
  assign rxf_o = rxf_q;
  assign ovr_o = ovr_q;
  assign per_o = per_q;
  assign fer_o = fer_q;
endmodule

// File: rtl/sync_serial_if.sv
module sync_serial_if
  import ssi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BRR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              txd_o,
  output logic              txd_oe_o,
  input  logic              rxd_i,
  output logic              irq_rxf_o,
  output logic              irq_txe_o,
  output logic              irq_tend_o
);
  ctrl_t             ctrl_q;
  logic [BRR_W-1:0]  brr_q;
  logic              locked, wr_ctrl, wr_brr, wr_txd, rd_clr, tx_kill, run;
  logic [2:0]        w1c;
  logic              rise_w, fall_w, lvl_w;
  logic [DATA_W-1:0] tdr_w, rdr_w;
  logic              txd_w, busy_w, txe_w, tend_w;
  logic              rxf_w, ovr_w, per_w, fer_w;

  assign locked  = ctrl_q.tx_en || ctrl_q.rx_en;
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_brr  = wr_en_i && (addr_i == A_BRR);
  assign wr_txd  = wr_en_i && (addr_i == A_TXD);
  assign rd_clr  = rd_en_i && (addr_i == A_RXD);
  assign w1c     = (wr_en_i && (addr_i == A_STAT)) ? wdata_i[5:3] : 3'b000;
  assign tx_kill = wr_ctrl && ctrl_q.tx_en && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      brr_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.tx_en   <= wdata_i[0];
        ctrl_q.rx_en   <= wdata_i[1];
        ctrl_q.ie_rxf  <= wdata_i[3];
        ctrl_q.ie_txe  <= wdata_i[4];
        ctrl_q.ie_tend <= wdata_i[5];
        if (!locked) ctrl_q.ext_clk <= wdata_i[2];
      end
      if (wr_brr && !locked) brr_q <= wdata_i[BRR_W-1:0];
    end
  end

  assign run = !ctrl_q.ext_clk && (busy_w || (ctrl_q.rx_en && !ovr_w));

  ssi_clk_gen #(.BRR_W(BRR_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ext_i (ctrl_q.ext_clk),
    .run_i (run),
    .brr_i (brr_q),
    .sck_i (sck_i),
    .sck_o (lvl_w),
    .rise_o(rise_w),
    .fall_o(fall_w)
  );

  ssi_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q.tx_en),
    .kill_i (tx_kill),
    .wr_i   (wr_txd),
    .wdata_i(wdata_i),
    .rise_i (rise_w),
    .fall_i (fall_w),
    .tdr_o  (tdr_w),
    .txd_o  (txd_w),
    .busy_o (busy_w),
    .txe_o  (txe_w),
    .tend_o (tend_w)
  );

  ssi_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl_q.rx_en),
    .rise_i  (rise_w),
    .rxd_i   (rxd_i),
    .rd_clr_i(rd_clr),
    .w1c_i   (w1c),
    .rdr_o   (rdr_w),
    .rxf_o   (rxf_w),
    .ovr_o   (ovr_w),
    .per_o   (per_w),
    .fer_o   (fer_w)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
      A_BRR:   rdata_o[BRR_W-1:0]  = brr_q;
      A_TXD:   rdata_o             = tdr_w;
      A_RXD:   rdata_o             = rdr_w;
      A_STAT:  rdata_o[STAT_W-1:0] = {fer_w, per_w, ovr_w, rxf_w, tend_w, txe_w};
      default: rdata_o             = '0;
    endcase
  end

  assign sck_o      = lvl_w;
  assign sck_oe_o   = !ctrl_q.ext_clk && locked;
  assign txd_o      = ctrl_q.tx_en ? txd_w : 1'b1;
  assign txd_oe_o   = ctrl_q.tx_en;
  assign irq_rxf_o  = ctrl_q.ie_rxf && rxf_w;
  assign irq_txe_o  = ctrl_q.ie_txe && txe_w;
  assign irq_tend_o = ctrl_q.ie_tend && tend_w;
endmodule

// File: rtl/ssi_chk.sv
module ssi_chk #(
  parameter int DATA_W = 8,
  parameter int BRR_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_en,
  input logic              rx_en,
  input logic              ext,
  input logic [BRR_W-1:0]  brr,
  input logic [DATA_W-1:0] rdr,
  input logic              rxf,
  input logic              ovr,
  input logic              txe,
  input logic              tend,
  input logic              sck_o,
  input logic              txd_o,
  input logic              txd_oe_o,
  input logic              rise,
  input logic              fall
);
  // R2
  cfg_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tx_en || rx_en) |-> ($stable(brr) && $stable(ext)));

  // R3
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!tx_en && !rx_en) |-> sck_o);

  // R3
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise, fall}));

  // R6
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr) |-> $stable(rdr));

  // R8
  tx_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en) |-> (txe && tend));

  // R9
  rx_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_en) |-> ($stable(rdr) && $stable(ovr) && $stable(rxf)));

  // R11
  txd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en |-> (txd_o && !txd_oe_o));
endmodule

bind sync_serial_if ssi_chk #(.DATA_W(DATA_W), .BRR_W(BRR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tx_en   (ctrl_q.tx_en),
  .rx_en   (ctrl_q.rx_en),
  .ext     (ctrl_q.ext_clk),
  .brr     (brr_q),
  .rdr     (rdr_w),
  .rxf     (rxf_w),
  .ovr     (ovr_w),
  .txe     (txe_w),
  .tend    (tend_w),
  .sck_o   (sck_o),
  .txd_o   (txd_o),
  .txd_oe_o(txd_oe_o),
  .rise    (rise_w),
  .fall    (fall_w)
);

// File: tb/sync_serial_if_tb_top.sv
`timescale 1ns/1ps
module sync_serial_if_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       sck_drv = 1'b1, rxd_drv = 1'b1, loop_sel = 1'b0;
  logic       sck_o, sck_oe_o, txd_o, txd_oe_o, rxd_i;
  logic       irq_rxf_o, irq_txe_o, irq_tend_o;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  assign rxd_i = loop_sel ? txd_o : rxd_drv;

  sync_serial_if dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sck_i(sck_drv), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .txd_o(txd_o), .txd_oe_o(txd_oe_o), .rxd_i(rxd_i),
    .irq_rxf_o(irq_rxf_o), .irq_txe_o(irq_txe_o), .irq_tend_o(irq_tend_o)
  );

  // {byte sent, byte received} per frame, full duplex on the external clock
  localparam logic [15:0] VEC [4] = '{16'hA5_3C, 16'h01_80, 16'hFF_00, 16'h6E_91};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic ext_bit(input logic b, output logic cap);
    sck_drv = 1'b0; rxd_drv = b;
    repeat (8) @(negedge clk_i);
    cap = txd_o;
    sck_drv = 1'b1;
    repeat (8) @(negedge clk_i);
  endtask

  task automatic ext_byte(input logic [7:0] rx_b, output logic [7:0] cap);
    for (int i = 0; i < 8; i++) ext_bit(rx_b[i], cap[i]);
  endtask

  task automatic wait_fall(output int cyc);
    logic p;
    p = sck_o;
    for (cyc = 1; cyc < 1000; cyc++) begin
      @(negedge clk_i);
      if (p && !sck_o) break;
      p = sck_o;
    end
  endtask

  task automatic count_falls(input int win, output int f);
    logic p;
    p = sck_o; f = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk_i);
      if (p && !sck_o) f++;
      p = sck_o;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++; n_chk++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, cap;
    int per, f;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(3'd4, d); chk("R1 status", d, 8'h03);
    chk("R1 pins", {txd_o, sck_o, txd_oe_o, sck_oe_o}, 4'b1100);
    chk("R1 irq", {irq_rxf_o, irq_txe_o, irq_tend_o}, 3'b000);

    // R2 lock of clock select and divider
    wr(3'd1, 8'h05); rd(3'd1, d); chk("R2 divider write", d, 8'h05);
    wr(3'd0, 8'h04); wr(3'd0, 8'h05);
    wr(3'd1, 8'h09); rd(3'd1, d); chk("R2 divider locked", d, 8'h05);
    wr(3'd0, 8'h01); rd(3'd0, d); chk("R2 clock select locked", d, 8'h05);
    chk("R10 sck_oe external", sck_oe_o, 1'b0);
    chk("R11 txd_oe on", txd_oe_o, 1'b1);

    // R4 R5 R10 table of full-duplex frames on the external clock
    wr(3'd0, 8'h07);
    for (int v = 0; v < 4; v++) begin
      wr(3'd2, VEC[v][15:8]);
      ext_byte(VEC[v][7:0], cap);
      chk("R4 tx bits", cap, VEC[v][15:8]);
      rd(3'd4, d); chk("R4 R5 status after frame", d & 8'h07, 8'h07);
      rd(3'd3, d); chk("R5 rx byte", d, VEC[v][7:0]);
      rd(3'd4, d); chk("R5 rxf cleared by read", d[2], 1'b0);
    end

    // R12 interrupt masking
    wr(3'd0, 8'h17);
    chk("R12 txe irq", {irq_rxf_o, irq_txe_o, irq_tend_o}, 3'b010);
    ext_byte(8'hC3, cap);
    wr(3'd0, 8'h0F);
    chk("R12 rxf irq", {irq_rxf_o, irq_txe_o, irq_tend_o}, 3'b100);
    wr(3'd0, 8'h27);
    chk("R12 tend irq", {irq_rxf_o, irq_txe_o, irq_tend_o}, 3'b001);

    // R6 overrun: second byte while full
    ext_byte(8'h11, cap);
    rd(3'd4, d); chk("R6 overrun set", d, 8'h0F);

    // R9 receiver off keeps flags and data
    wr(3'd0, 8'h05);
    rd(3'd4, d); chk("R9 flags kept", d, 8'h0F);
    rd(3'd3, d); chk("R9 R6 data kept", d, 8'hC3);

    // R6 write-1-to-clear, R11 receiver off ignores traffic
    wr(3'd4, 8'h38);
    rd(3'd4, d); chk("R6 overrun cleared", d, 8'h03);
    ext_byte(8'h00, cap);
    rd(3'd4, d); chk("R11 rx off no byte", d, 8'h03);
    rd(3'd3, d); chk("R11 rx off data", d, 8'hC3);

    // R8 transmitter off mid frame
    wr(3'd2, 8'h00);
    for (int i = 0; i < 3; i++) ext_bit(1'b1, cap[i]);
    chk("R4 partial bits", cap[2:0], 3'b000);
    wr(3'd0, 8'h04);
    chk("R8 pins released", {txd_oe_o, txd_o}, 2'b01);
    rd(3'd4, d); chk("R8 flags", d, 8'h03);
    wr(3'd0, 8'h05);
    ext_byte(8'hFF, cap);
    chk("R8 nothing resent", cap, 8'hFF);

    // R3 R7 internal free-running receive clock
    wr(3'd0, 8'h00); wr(3'd0, 8'h00);
    wr(3'd1, 8'h03);
    rxd_drv = 1'b1;
    wr(3'd0, 8'h02);
    chk("R3 sck_oe internal", sck_oe_o, 1'b1);
    wait_fall(per); wait_fall(per);
    chk("R3 period N=3", per, 8);
    repeat (70) @(negedge clk_i);
    rd(3'd4, d); chk("R7 first byte in", d, 8'h07);
    wait_fall(per);
    chk("R7 clock keeps running", per, 8);
    repeat (100) @(negedge clk_i);
    rd(3'd4, d); chk("R6 R7 overrun internal", d, 8'h0F);
    count_falls(30, f);
    chk("R6 clock stopped", {f[7:0], sck_o}, {8'd0, 1'b1});
    rd(3'd3, d); chk("R5 all ones byte", d, 8'hFF);
    wr(3'd0, 8'h00); wr(3'd4, 8'h08);

    // R4 R5 internal loopback, N=1
    loop_sel = 1'b1;
    wr(3'd1, 8'h01);
    wr(3'd2, 8'h5A);
    wr(3'd0, 8'h03);
    repeat (300) @(negedge clk_i);
    rd(3'd4, d); chk("R6 loopback status", d, 8'h0F);
    rd(3'd3, d); chk("R4 R5 loopback byte", d, 8'h5A);
    chk("R6 loopback clock idle", sck_o, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule